// File: doc/BRIEF.md
# Over-Current Pulse-Skip Guard

This block is the digital timing core of a switching regulator's cycle-by-cycle over-current protection. An external comparator raises a current-limit flag. The block looks at that flag once per switching period, on a one-clock strobe that marks the start of the period. When the flag is found high while the block is idle, the block blocks the high-side gate drive for that period and for the eight periods that follow.

After the skip period the block opens a re-check window that covers periods nine to sixteen, counted from the triggering period as zero. If the flag is seen again at the start of any period in that window, the block sends a one-clock fault pulse to an external fault latch. That period is also blocked, and a fresh skip period begins. If the window passes with no flag, the block goes back to idle and treats the next flag as a new first event.

A soft-start mask input keeps faults from being reported while the output is still ramping up. Skipping still works while the mask is high. All sensing and comparison happen outside the block.

Top module: `oc_pulse_skip_guard`

## Requirements
- R1: A synchronous active-high reset drives `hs_inhibit` and `oc_fault` low and returns the block to idle. This holds even when reset arrives during a skip period, and the next flag after reset is then handled as a first event.
- R2: While idle, a strobe with `ilim_det` low leaves `hs_inhibit` low and `oc_fault` low.
- R3: While idle, a strobe with `ilim_det` high sets `hs_inhibit` high on the next clock edge. This blocks the high side for that period (period 0).
- R4: `hs_inhibit` stays high through periods 1 to 8. A flag sampled in those periods is ignored: it produces no fault and does not extend the skip.
- R5: A flag sampled at the strobe of any period from 9 to 16, with `ss_mask` low, produces `oc_fault` high for exactly one clock. The pulse appears on the edge that samples the strobe.
- R6: If no flag is sampled in periods 9 to 16, `hs_inhibit` falls at the strobe of period 9 and the block is idle after period 16. A later flag then starts a new skip with no fault.
- R7: A flag sampled in the window blocks that period (`hs_inhibit` high) and restarts a full eight-period skip, which is followed by a new window.
- R8: With `ss_mask` high at the re-detecting strobe, no fault pulse is produced. The skip restart of R7 still happens.
- R9: Both outputs change only on the clock edge that samples a strobe. The 5-bit period counter never exceeds 16 and reads zero whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | One-clock strobe at the start of each switching period |
| ilim_det | input | 1 | Current-limit flag from the external comparator |
| ss_mask | input | 1 | High while soft-start is below its fault-enable level |
| hs_inhibit | output | 1 | Registered high-side gate block |
| oc_fault | output | 1 | Registered one-clock over-current fault pulse |

## Verification
The tests drive several kinds of flag sequence. A quiet sequence shows that idle produces no false skip. A single isolated event with a clean window separates "return to idle" from "stay armed": the probe flag after period 16 must skip without a fault. Re-detects at the first and the last window period pin down both window edges. A flag inside the skip period shows that it is ignored. The same re-detect with the soft-start mask high shows that the mask blocks the fault but not the skip. A reset during a skip, with the flag still held between strobes, checks that outputs move only at strobes and that reset clears the armed state.

// File: rtl/oc_skip_pkg.sv
package oc_skip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SKIP  = 2'd1,
    ST_WATCH = 2'd2
  } oc_state_t;
endpackage

// File: rtl/oc_cycle_counter.sv
// Switching-period index counter; clear has priority over increment.
module oc_cycle_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/oc_skip_ctrl.sv
// Sequencer: idle -> skip (periods 0..SKIP) -> watch window -> idle or restart.
module oc_skip_ctrl
  import oc_skip_pkg::*;
#(
  parameter int SKIP_CYCLES  = 8,
  parameter int WATCH_CYCLES = 8,
  parameter int CNT_W        = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_start,
  input  logic             ilim_det,
  input  logic             ss_mask,
  input  logic [CNT_W-1:0] cnt,
  output oc_state_t        state,
  output logic             cnt_clr,
  output logic             cnt_inc,
  output logic             inh_set,
  output logic             inh_clr,
  output logic             fault_req
);
  localparam logic [CNT_W-1:0] WIN_FIRST = CNT_W'(SKIP_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(SKIP_CYCLES + WATCH_CYCLES);

  oc_state_t        state_q, state_d;
  logic [CNT_W-1:0] nxt_idx;
  logic             in_window;

  assign nxt_idx   = cnt + CNT_W'(1);
  assign in_window = (nxt_idx >= WIN_FIRST);
  assign state     = state_q;

  always_comb begin
    state_d   = state_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    inh_set   = 1'b0;
    inh_clr   = 1'b0;
    fault_req = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cnt_clr = 1'b1;
        if (cyc_start && ilim_det) begin
          state_d = ST_SKIP;
          inh_set = 1'b1;
        end
      end
      default: begin
        if (cyc_start) begin
          if (in_window && ilim_det) begin
            fault_req = !ss_mask;
            inh_set   = 1'b1;
            cnt_clr   = 1'b1;
            state_d   = ST_SKIP;
          end else if (nxt_idx == WIN_LAST) begin
            state_d = ST_IDLE;
            cnt_clr = 1'b1;
            inh_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
            if (nxt_idx == WIN_FIRST) begin
              state_d = ST_WATCH;
              inh_clr = 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/oc_out_regs.sv
// Registered outputs: set-dominant inhibit flop and a one-clock fault flop.
module oc_out_regs (
  input  logic clk,
  input  logic rst,
  input  logic inh_set,
  input  logic inh_clr,
  input  logic fault_req,
  output logic hs_inhibit,
  output logic oc_fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_inhibit <= 1'b0;
      oc_fault   <= 1'b0;
    end else begin
      if (inh_set)      hs_inhibit <= 1'b1;
      else if (inh_clr) hs_inhibit <= 1'b0;
      oc_fault <= fault_req;
    end
  end
endmodule

// File: rtl/oc_pulse_skip_guard.sv
module oc_pulse_skip_guard
  import oc_skip_pkg::*;
#(
  parameter int SKIP_CYCLES  = 8,
  parameter int WATCH_CYCLES = 8,
  parameter int CNT_W        = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic ilim_det,
  input  logic ss_mask,
  output logic hs_inhibit,
  output logic oc_fault
);
  logic [CNT_W-1:0] cnt_w;
  oc_state_t        state_w;
  logic             busy_w;
  logic             cnt_clr, cnt_inc, inh_set, inh_clr, fault_req;

  assign busy_w = (state_w != ST_IDLE);

  oc_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (cnt_w)
  );

  oc_skip_ctrl #(
    .SKIP_CYCLES (SKIP_CYCLES),
    .WATCH_CYCLES(WATCH_CYCLES),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cyc_start(cyc_start),
    .ilim_det (ilim_det),
    .ss_mask  (ss_mask),
    .cnt      (cnt_w),
    .state    (state_w),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .inh_set  (inh_set),
    .inh_clr  (inh_clr),
    .fault_req(fault_req)
  );

  oc_out_regs u_out (
    .clk       (clk),
    .rst       (rst),
    .inh_set   (inh_set),
    .inh_clr   (inh_clr),
    .fault_req (fault_req),
    .hs_inhibit(hs_inhibit),
    .oc_fault  (oc_fault)
  );
endmodule

// File: rtl/oc_pulse_skip_guard_chk.sv
module oc_pulse_skip_guard_chk #(
  parameter int SKIP_CYCLES  = 8,
  parameter int WATCH_CYCLES = 8,
  parameter int CNT_W        = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_start,
  input logic             ilim_det,
  input logic             ss_mask,
  input logic             hs_inhibit,
  input logic             oc_fault,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cyc_start && ilim_det)) |=> (!hs_inhibit && !oc_fault));

  p_first_event_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && cyc_start && ilim_det) |=> (hs_inhibit && !oc_fault));

  p_skip_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && hs_inhibit && int'(cnt) < SKIP_CYCLES) |=> (hs_inhibit && !oc_fault));

  p_fault_from_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    oc_fault |-> ($past(cyc_start) && $past(ilim_det)));

  p_fault_single_r5: assert property (@(posedge clk) disable iff (rst)
    oc_fault |=> !oc_fault);

  p_fault_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    oc_fault |-> (hs_inhibit && busy && cnt == '0));

  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    oc_fault |-> !$past(ss_mask));

  p_stable_between_r9: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |=> ($stable(hs_inhibit) && !oc_fault));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cnt == '0 && !hs_inhibit));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= SKIP_CYCLES + WATCH_CYCLES);
endmodule

bind oc_pulse_skip_guard oc_pulse_skip_guard_chk #(
  .SKIP_CYCLES (SKIP_CYCLES),
  .WATCH_CYCLES(WATCH_CYCLES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_start (cyc_start),
  .ilim_det  (ilim_det),
  .ss_mask   (ss_mask),
  .hs_inhibit(hs_inhibit),
  .oc_fault  (oc_fault),
  .busy      (busy_w),
  .cnt       (cnt_w)
);

// File: tb/oc_pulse_skip_guard_test.sv
`timescale 1ns/1ps
module oc_pulse_skip_guard_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0;
  logic ilim_det = 1'b0;
  logic ss_mask = 1'b0;
  logic hs_inhibit, oc_fault;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oc_pulse_skip_guard uut (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .ilim_det  (ilim_det),
    .ss_mask   (ss_mask),
    .hs_inhibit(hs_inhibit),
    .oc_fault  (oc_fault)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One switching period of four clocks. The flag is held across the period so
  // that only the strobe sample can matter; outputs read after the strobe edge,
  // then rechecked at the end of the period (no change, no second fault clock).
  task automatic pwm_cyc(input bit flag, input bit mask,
                         output logic inh, output logic flt);
    @(negedge clk);
    cyc_start = 1'b1; ilim_det = flag; ss_mask = mask;
    @(negedge clk);
    cyc_start = 1'b0;
    inh = hs_inhibit; flt = oc_fault;
    @(negedge clk);
    chk(oc_fault == 1'b0, "R5", "fault wider than one clock", oc_fault, 0);
    @(negedge clk);
    chk(hs_inhibit == inh, "R9", "inhibit moved between strobes", hs_inhibit, inh);
    ilim_det = 1'b0;
  endtask

  // Periods 1..16 after a (re)start with no flags: skip, then a clean window.
  task automatic run_clean_tail(input string req);
    logic inh, flt;
    for (int j = 1; j <= 16; j++) begin
      pwm_cyc(1'b0, 1'b0, inh, flt);
      chk(inh == (j <= 8), req, $sformatf("inhibit in period %0d", j), inh, int'(j <= 8));
      chk(flt == 1'b0, req, $sformatf("fault in period %0d", j), flt, 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(hs_inhibit == 1'b0, "R1", "inhibit in reset", hs_inhibit, 0);
    chk(oc_fault == 1'b0, "R1", "fault in reset", oc_fault, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(hs_inhibit == 1'b0 && oc_fault == 1'b0, "R1", "outputs after reset",
        {hs_inhibit, oc_fault}, 0);
  endtask

  task automatic t_quiet();
    logic inh, flt;
    for (int k = 0; k < 6; k++) begin
      pwm_cyc(1'b0, k[0], inh, flt);
      chk(inh == 1'b0, "R2", "inhibit with no flag", inh, 0);
      chk(flt == 1'b0, "R2", "fault with no flag", flt, 0);
    end
  endtask

  // recheck: window period with a flag (0 = none); mask applies at that strobe.
  task automatic t_event(input int recheck, input bit mask);
    logic inh, flt;
    bit   hit = 1'b0;
    pwm_cyc(1'b1, 1'b0, inh, flt);
    chk(inh == 1'b1, "R3", "inhibit on first event", inh, 1);
    chk(flt == 1'b0, "R3", "fault on first event", flt, 0);
    for (int k = 1; k <= 8; k++) begin
      pwm_cyc(k == 3 || k == 8, 1'b0, inh, flt);
      chk(inh == 1'b1, "R4", $sformatf("skip period %0d", k), inh, 1);
      chk(flt == 1'b0, "R4", $sformatf("flag ignored period %0d", k), flt, 0);
    end
    for (int k = 9; k <= 16; k++) begin
      if (!hit) begin
        if (k == recheck) begin
          hit = 1'b1;
          pwm_cyc(1'b1, mask, inh, flt);
          if (mask) chk(flt == 1'b0, "R8", "masked re-detect fault", flt, 0);
          else      chk(flt == 1'b1, "R5", $sformatf("re-detect fault period %0d", k), flt, 1);
          chk(inh == 1'b1, "R7", "re-detect blocks period", inh, 1);
        end else begin
          pwm_cyc(1'b0, 1'b0, inh, flt);
          chk(inh == 1'b0, "R6", $sformatf("window period %0d inhibit", k), inh, 0);
          chk(flt == 1'b0, "R6", $sformatf("window period %0d fault", k), flt, 0);
        end
      end
    end
    if (hit) begin
      run_clean_tail("R7");
    end else begin
      pwm_cyc(1'b1, 1'b0, inh, flt);
      chk(inh == 1'b1, "R6", "fresh event after window", inh, 1);
      chk(flt == 1'b0, "R6", "no fault after idle return", flt, 0);
      run_clean_tail("R6");
    end
  endtask

  task automatic t_reset_mid_skip();
    logic inh, flt;
    pwm_cyc(1'b1, 1'b0, inh, flt);
    chk(inh == 1'b1, "R3", "event before reset", inh, 1);
    pwm_cyc(1'b0, 1'b0, inh, flt);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(hs_inhibit == 1'b0 && oc_fault == 1'b0, "R1", "outputs after mid-skip reset",
        {hs_inhibit, oc_fault}, 0);
    pwm_cyc(1'b1, 1'b0, inh, flt);
    chk(inh == 1'b1 && flt == 1'b0, "R1", "first event after reset (inh,flt)",
        {inh, flt}, 2);
    run_clean_tail("R1");
  endtask

  initial begin
    t_reset();
    t_quiet();
    t_event(0, 1'b0);
    t_event(9, 1'b0);
    t_event(16, 1'b0);
    t_event(12, 1'b1);
    t_reset_mid_skip();
    t_quiet();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule